// File: doc/BRIEF.md
# Data-Link Bit-Oriented Message Receiver

This block watches the serial data-link channel carried in the framing-bit positions of an extended-superframe T1 or J1 stream. It searches for 16-bit message codewords, checks each 6-bit payload by repetition, and reports an accepted message together with a sticky interrupt flag. When the sender stops sending a message, the channel carries an idle code. The block detects that idle code with the same repetition rule and raises a second sticky flag. The idle code depends on whether the line runs in T1 or J1 mode.

The data-link bits come from an upstream superframe extractor. A bit is taken only in a cycle where both the bit clock enable and the data-link valid strobe are high. The codeword boundary is found by sliding over the bit stream until a codeword or idle pattern lines up. After that, the receiver steps through the stream in fixed 16-bit blocks, and it returns to sliding when a block matches neither pattern. Each block goes into a ten-deep history. A vote over the most recent five or ten entries decides whether a message or idle code is declared.

Top module: `dl_msg_rx`

## Requirements
- R1: A codeword is 16 bits received in this order: eight ones, a zero, six message bits, and a final zero. The first message bit received is bit 5 of `msg_code`.
- R2: With `vote_long` low, a message is declared when the newest codeword and at least 3 of the 4 codewords before it carry the same 6-bit content.
- R3: With `vote_long` high, a message is declared only when at least 8 of the last 10 codewords carry the same content. Seven matches are not enough.
- R4: A message field of 6'h3F is never declared as a message.
- R5: In T1 mode (`j1_mode` low), the 16-bit word 16'hFFFF is the idle code. It is declared by the same vote as messages and sets `idle_flag`.
- R6: In J1 mode, 16'hFF7E is the idle code and 16'hFFFF is neither idle nor a message.
- R7: `msg_flag` and `idle_flag` are sticky. They clear when `clr_msg` or `clr_idle` is high for one cycle. A new declaration in the same cycle wins over the clear.
- R8: `irq` is high exactly when (`msg_flag` and `msg_ie`) or (`idle_flag` and `idle_ie`).
- R9: A message equal to the one last declared is not declared again until an idle code or a different message has been declared. A declaration loads `msg_code`, and `msg_code` changes at no other time.
- R10: Bits arrive only in cycles where `bit_en` and `dl_valid` are both high. In any other cycle, `dl_bit` has no effect.
- R11: After a synchronous reset, `msg_code` is 0 and `msg_flag`, `idle_flag` and `irq` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_en | input | 1 | Bit clock enable |
| dl_valid | input | 1 | Marks the current bit as a data-link bit |
| dl_bit | input | 1 | Data-link bit value |
| j1_mode | input | 1 | 1 selects J1 idle code, 0 selects T1 |
| vote_long | input | 1 | 1 selects the 8-of-10 vote, 0 selects 4-of-5 |
| msg_ie | input | 1 | Lets `msg_flag` drive `irq` |
| idle_ie | input | 1 | Lets `idle_flag` drive `irq` |
| clr_msg | input | 1 | Write-one-to-clear pulse for `msg_flag` |
| clr_idle | input | 1 | Write-one-to-clear pulse for `idle_flag` |
| msg_code | output | 6 | Last declared message |
| msg_flag | output | 1 | Sticky message-declared flag |
| idle_flag | output | 1 | Sticky idle-declared flag |
| irq | output | 1 | Interrupt output |

## Verification
The bench builds the block with its default parameters: a 16-bit codeword, a 6-bit message and a ten-entry history with 4-of-5 and 8-of-10 thresholds. Because the history holds ten entries, the 7-versus-8 boundary of the long vote can be tested, along with the 3-versus-4 boundary of the short vote. A broken run of the form X X Y X X shows that the vote counts matches inside the window rather than consecutive ones. The J1 idle word is also a codeword with an all-ones message, so the same stimulus in the two modes separates idle detection from all-ones rejection.

// File: rtl/dl_msg_pkg.sv
package dl_msg_pkg;

  typedef enum logic [1:0] {
    EV_NONE = 2'd0,
    EV_CODE = 2'd1,
    EV_IDLE = 2'd2
  } ev_kind_t;

  typedef enum logic [1:0] {
    DECL_NONE = 2'd0,
    DECL_MSG  = 2'd1,
    DECL_IDLE = 2'd2
  } decl_t;

endpackage

// File: rtl/dl_cw_aligner.sv
module dl_cw_aligner
  import dl_msg_pkg::*;
#(
  parameter int              CW_W     = 16,
  parameter int              MSG_W    = 6,
  parameter logic [CW_W-1:0] IDLE_T1  = 16'hFFFF,
  parameter logic [CW_W-1:0] IDLE_J1  = 16'hFF7E
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             take,
  input  logic             din,
  input  logic             j1_mode,
  output logic             ev_valid,
  output ev_kind_t         ev_kind,
  output logic [MSG_W-1:0] ev_code
);
  localparam int HDR_W = CW_W - MSG_W - 2;
  localparam int CNT_W = $clog2(CW_W);

  logic [CW_W-1:0]  sr_q, sr_d;
  logic             locked_q;
  logic [CNT_W-1:0] cnt_q;
  logic             is_cw, is_idle, boundary;
  ev_kind_t         kind_d;

  always_comb begin
    sr_d    = {sr_q[CW_W-2:0], din};
    is_cw   = (&sr_d[CW_W-1 -: HDR_W]) && !sr_d[MSG_W+1] && !sr_d[0];
    is_idle = (sr_d == (j1_mode ? IDLE_J1 : IDLE_T1));
    kind_d  = is_idle ? EV_IDLE : (is_cw ? EV_CODE : EV_NONE);
    boundary = locked_q ? (cnt_q == CNT_W'(CW_W-1)) : (kind_d != EV_NONE);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sr_q     <= '0;
      locked_q <= 1'b0;
      cnt_q    <= '0;
      ev_valid <= 1'b0;
      ev_kind  <= EV_NONE;
      ev_code  <= '0;
    end else begin
      ev_valid <= 1'b0;
      if (take) begin
        sr_q <= sr_d;
        if (boundary) begin
          ev_valid <= 1'b1;
          ev_kind  <= kind_d;
          ev_code  <= sr_d[MSG_W:1];
          locked_q <= (kind_d != EV_NONE);
          cnt_q    <= '0;
        end else if (locked_q) begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  // R10
  ev_after_take_chk: assert property (@(posedge clk) disable iff (rst)
    ev_valid |-> $past(take));

endmodule

// File: rtl/dl_vote_window.sv
module dl_vote_window
  import dl_msg_pkg::*;
#(
  parameter int MSG_W   = 6,
  parameter int DEPTH   = 10,
  parameter int SHORT_N = 5,
  parameter int SHORT_K = 4,
  parameter int LONG_N  = 10,
  parameter int LONG_K  = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             long_mode,
  input  logic             ev_valid,
  input  ev_kind_t         ev_kind,
  input  logic [MSG_W-1:0] ev_code,
  output logic             dec_msg,
  output logic             dec_idle,
  output logic [MSG_W-1:0] dec_code
);
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam int OLD_N = DEPTH - 1;

  typedef struct packed {
    ev_kind_t         kind;
    logic [MSG_W-1:0] code;
  } entry_t;

  entry_t           hist_q [OLD_N];
  entry_t           ev_in;
  logic [CNT_W-1:0] cnt_s, cnt_l;
  logic             hit;

  always_comb begin
    ev_in = '{kind: ev_kind, code: ev_code};
    cnt_s = CNT_W'(1);
    cnt_l = CNT_W'(1);
    for (int i = 0; i < OLD_N; i++) begin
      if (i < SHORT_N - 1) cnt_s = cnt_s + CNT_W'(hist_q[i] == ev_in);
      if (i < LONG_N - 1)  cnt_l = cnt_l + CNT_W'(hist_q[i] == ev_in);
    end
    hit = long_mode ? (cnt_l >= CNT_W'(LONG_K)) : (cnt_s >= CNT_W'(SHORT_K));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < OLD_N; i++) hist_q[i] <= '0;
      dec_msg  <= 1'b0;
      dec_idle <= 1'b0;
      dec_code <= '0;
    end else begin
      dec_msg  <= 1'b0;
      dec_idle <= 1'b0;
      if (ev_valid) begin
        hist_q[0] <= ev_in;
        for (int i = 1; i < OLD_N; i++) hist_q[i] <= hist_q[i-1];
        dec_msg  <= hit && (ev_kind == EV_CODE) && !(&ev_code);
        dec_idle <= hit && (ev_kind == EV_IDLE);
        dec_code <= ev_code;
      end
    end
  end

  // R4
  no_all_ones_chk: assert property (@(posedge clk) disable iff (rst)
    dec_msg |-> !(&dec_code));

  // R2
  dec_after_event_chk: assert property (@(posedge clk) disable iff (rst)
    (dec_msg || dec_idle) |-> $past(ev_valid));

endmodule

// File: rtl/dl_msg_rx.sv
module dl_msg_rx
  import dl_msg_pkg::*;
#(
  parameter int CW_W       = 16,
  parameter int MSG_W      = 6,
  parameter int HIST_DEPTH = 10,
  parameter int SHORT_N    = 5,
  parameter int SHORT_K    = 4,
  parameter int LONG_N     = 10,
  parameter int LONG_K     = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bit_en,
  input  logic             dl_valid,
  input  logic             dl_bit,
  input  logic             j1_mode,
  input  logic             vote_long,
  input  logic             msg_ie,
  input  logic             idle_ie,
  input  logic             clr_msg,
  input  logic             clr_idle,
  output logic [MSG_W-1:0] msg_code,
  output logic             msg_flag,
  output logic             idle_flag,
  output logic             irq
);
  logic             take;
  logic             ev_valid;
  ev_kind_t         ev_kind;
  logic [MSG_W-1:0] ev_code;
  logic             dec_msg, dec_idle;
  logic [MSG_W-1:0] dec_code;
  decl_t            last_q;
  logic             msg_set, idle_set;

  assign take = bit_en && dl_valid;

  dl_cw_aligner #(
    .CW_W  (CW_W),
    .MSG_W (MSG_W)
  ) u_align (
    .clk      (clk),
    .rst      (rst),
    .take     (take),
    .din      (dl_bit),
    .j1_mode  (j1_mode),
    .ev_valid (ev_valid),
    .ev_kind  (ev_kind),
    .ev_code  (ev_code)
  );

  dl_vote_window #(
    .MSG_W   (MSG_W),
    .DEPTH   (HIST_DEPTH),
    .SHORT_N (SHORT_N),
    .SHORT_K (SHORT_K),
    .LONG_N  (LONG_N),
    .LONG_K  (LONG_K)
  ) u_vote (
    .clk       (clk),
    .rst       (rst),
    .long_mode (vote_long),
    .ev_valid  (ev_valid),
    .ev_kind   (ev_kind),
    .ev_code   (ev_code),
    .dec_msg   (dec_msg),
    .dec_idle  (dec_idle),
    .dec_code  (dec_code)
  );

  assign msg_set  = dec_msg && !((last_q == DECL_MSG) && (msg_code == dec_code));
  assign idle_set = dec_idle && (last_q != DECL_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      msg_code  <= '0;
      msg_flag  <= 1'b0;
      idle_flag <= 1'b0;
      last_q    <= DECL_NONE;
    end else begin
      if (msg_set) begin
        msg_code <= dec_code;
        last_q   <= DECL_MSG;
      end else if (idle_set) begin
        last_q   <= DECL_IDLE;
      end
      msg_flag  <= msg_set  || (msg_flag  && !clr_msg);
      idle_flag <= idle_set || (idle_flag && !clr_idle);
    end
  end

  assign irq = (msg_flag && msg_ie) || (idle_flag && idle_ie);

  // R7
  msg_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(msg_flag) |-> $past(dec_msg));

  // R5
  idle_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(idle_flag) |-> $past(dec_idle));

  // R7
  msg_clr_chk: assert property (@(posedge clk) disable iff (rst)
    (clr_msg && !dec_msg) |=> !msg_flag);

  // R9
  code_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(msg_code) |-> ($past(dec_msg) && msg_flag));

endmodule

// File: tb/dl_msg_rx_tb.sv
`timescale 1ns/1ps
module dl_msg_rx_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bit_en = 1'b0, dl_valid = 1'b0, dl_bit = 1'b0;
  logic       j1_mode = 1'b0, vote_long = 1'b0;
  logic       msg_ie = 1'b0, idle_ie = 1'b0, clr_msg = 1'b0, clr_idle = 1'b0;
  logic [5:0] msg_code;
  logic       msg_flag, idle_flag, irq;
  int         n_chk = 0, n_fail = 0;
  logic       noisy = 1'b0;
  logic       done = 1'b0;

  always #4 clk = ~clk;

  dl_msg_rx u_dut (
    .clk(clk), .rst(rst), .bit_en(bit_en), .dl_valid(dl_valid), .dl_bit(dl_bit),
    .j1_mode(j1_mode), .vote_long(vote_long), .msg_ie(msg_ie), .idle_ie(idle_ie),
    .clr_msg(clr_msg), .clr_idle(clr_idle), .msg_code(msg_code),
    .msg_flag(msg_flag), .idle_flag(idle_flag), .irq(irq)
  );

  typedef struct packed {
    logic        j1;
    logic        lng;
    logic [15:0] pat;
    logic [3:0]  reps;
    logic        exp_msg;
    logic        exp_idle;
    logic [5:0]  exp_code;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 1'b0, 16'hFF2A, 4'd4, 1'b1, 1'b0, 6'h15},  // R1 R2 four of five
    '{1'b0, 1'b0, 16'hFF2A, 4'd3, 1'b0, 1'b0, 6'h00},  // R2 three is short
    '{1'b0, 1'b1, 16'hFF2A, 4'd7, 1'b0, 1'b0, 6'h00},  // R3 seven is short
    '{1'b0, 1'b1, 16'hFF2A, 4'd8, 1'b1, 1'b0, 6'h15},  // R3 eight of ten
    '{1'b0, 1'b0, 16'hFFFF, 4'd4, 1'b0, 1'b1, 6'h00},  // R5 T1 idle
    '{1'b1, 1'b0, 16'hFF7E, 4'd4, 1'b0, 1'b1, 6'h00},  // R6 J1 idle
    '{1'b0, 1'b0, 16'hFF7E, 4'd5, 1'b0, 1'b0, 6'h00},  // R4 all-ones message
    '{1'b1, 1'b0, 16'hFFFF, 4'd4, 1'b0, 1'b0, 6'h00},  // R6 not idle in J1
    '{1'b1, 1'b0, 16'hFF54, 4'd4, 1'b1, 1'b0, 6'h2A}   // R1 J1 message
  };

  function automatic logic [15:0] cw(input logic [5:0] c);
    return {8'hFF, 1'b0, c, 1'b0};
  endfunction

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic send_bit(input logic b);
    if (noisy) begin
      @(negedge clk); bit_en = 1'b0; dl_valid = 1'b1; dl_bit = ~b;
      @(negedge clk); bit_en = 1'b1; dl_valid = 1'b0; dl_bit = ~b;
    end
    @(negedge clk); bit_en = 1'b1; dl_valid = 1'b1; dl_bit = b;
  endtask

  task automatic send_word(input logic [15:0] w);
    for (int i = 15; i >= 0; i--) send_bit(w[i]);
  endtask

  task automatic idle_cycles(input int n);
    @(negedge clk); bit_en = 1'b0; dl_valid = 1'b0; dl_bit = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1; bit_en = 1'b0; dl_valid = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic pulse_clr(input logic m, input logic i);
    @(negedge clk); clr_msg = m; clr_idle = i;
    @(negedge clk); clr_msg = 1'b0; clr_idle = 1'b0;
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    for (int v = 0; v < NV; v++) begin
      j1_mode = VECS[v].j1;
      vote_long = VECS[v].lng;
      do_reset();
      for (int k = 0; k < 20; k++) send_bit(1'b0);
      for (int r = 0; r < int'(VECS[v].reps); r++) send_word(VECS[v].pat);
      idle_cycles(5);
      check($sformatf("R2/R3/R4 row%0d msg_flag", v), {15'd0, msg_flag}, {15'd0, VECS[v].exp_msg});
      check($sformatf("R5/R6 row%0d idle_flag", v), {15'd0, idle_flag}, {15'd0, VECS[v].exp_idle});
      if (VECS[v].exp_msg) check($sformatf("R1 row%0d msg_code", v), {10'd0, msg_code}, {10'd0, VECS[v].exp_code});
    end

    // R11 reset state
    j1_mode = 1'b0; vote_long = 1'b0;
    do_reset();
    @(negedge clk);
    check("R11 msg_flag", {15'd0, msg_flag}, 16'd0);
    check("R11 idle_flag", {15'd0, idle_flag}, 16'd0);
    check("R11 msg_code", {10'd0, msg_code}, 16'd0);
    check("R11 irq", {15'd0, irq}, 16'd0);

    // R2 R10 broken run with noise cycles between bits
    noisy = 1'b1;
    for (int k = 0; k < 20; k++) send_bit(1'b0);
    send_word(cw(6'h15)); send_word(cw(6'h15)); send_word(cw(6'h2A)); send_word(cw(6'h15));
    idle_cycles(5);
    check("R2 three of five", {15'd0, msg_flag}, 16'd0);
    send_word(cw(6'h15));
    idle_cycles(5);
    check("R10 R2 four of five gapped", {15'd0, msg_flag}, 16'd1);
    check("R10 msg_code", {10'd0, msg_code}, 16'h0015);
    noisy = 1'b0;

    // R8 interrupt gating
    check("R8 irq masked", {15'd0, irq}, 16'd0);
    msg_ie = 1'b1; @(negedge clk);
    check("R8 irq enabled", {15'd0, irq}, 16'd1);

    // R7 clear, R9 no repeat declaration
    pulse_clr(1'b1, 1'b0);
    check("R7 msg clear", {15'd0, msg_flag}, 16'd0);
    check("R8 irq after clear", {15'd0, irq}, 16'd0);
    for (int r = 0; r < 4; r++) send_word(cw(6'h15));
    idle_cycles(5);
    check("R9 same message held off", {15'd0, msg_flag}, 16'd0);

    // R5 idle, R8 idle enable
    for (int r = 0; r < 4; r++) send_word(16'hFFFF);
    idle_cycles(5);
    check("R5 idle flag", {15'd0, idle_flag}, 16'd1);
    check("R8 irq idle masked", {15'd0, irq}, 16'd0);
    idle_ie = 1'b1; @(negedge clk);
    check("R8 irq idle enabled", {15'd0, irq}, 16'd1);
    pulse_clr(1'b0, 1'b1);
    check("R7 idle clear", {15'd0, idle_flag}, 16'd0);

    // R9 same message accepted after idle
    for (int r = 0; r < 4; r++) send_word(cw(6'h15));
    idle_cycles(5);
    check("R9 after idle", {15'd0, msg_flag}, 16'd1);
    check("R9 code after idle", {10'd0, msg_code}, 16'h0015);

    // R9 different message replaces code
    pulse_clr(1'b1, 1'b0);
    for (int r = 0; r < 4; r++) send_word(cw(6'h2A));
    idle_cycles(5);
    check("R9 new message flag", {15'd0, msg_flag}, 16'd1);
    check("R9 new message code", {10'd0, msg_code}, 16'h002A);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule